// File: doc/BRIEF.md
# Enhanced-Mode UART Register Bank with Protected Shadow Fields

This block holds the control and status registers of a 16550-style serial port that has an enhanced operating mode. It keeps the interrupt-enable, interrupt-status, FIFO-control, line-control, modem-control, line-status, modem-status, scratch and enhanced-configuration registers. A host reaches them through a plain address, write-data, write-strobe and read-strobe port. The read data is combinational on the address.

Some upper bit fields belong to the enhanced mode. Bit 4 of the enhanced-configuration register guards them. While that bit is 1, the fields behave like ordinary storage. When software clears the bit, the block copies the guarded fields into a hidden shadow and then shows them as zero. Legacy drivers that write whole bytes then see only the fields they know about, and cannot change the others. When software sets the bit again, the block puts the shadowed values back. Interrupt-code bits, line-status bits and modem pins come from neighbouring logic through input ports. The block registers them or passes them through.

Top module: `uart_shreg_bank`

## Requirements
- R1: After reset, reads return the following: IER=0x00, ISR=0x01, FCR=0x00, LCR=0x00, MCR=0x00, LSR=0x60, MSR[3:0]=0, scratch=0xFF, enhanced register=0x00.
- R2: Address map (addr_i): 0 IER, 1 ISR (read only), 2 FCR, 3 LCR, 4 MCR, 5 LSR (read only), 6 MSR (read only), 7 scratch, 8 enhanced register. The writable registers read back their stored value in the cycle after the write. LCR, scratch and the enhanced register store all 8 bits.
- R3: While enhanced register bit 4 is 0, guarded fields read as zero. The guarded fields are IER[7:4], FCR[5:4], MCR[7:5] and ISR[5:4]. Writes to those positions are ignored, and the other bits of the same write still update.
- R4: While enhanced register bit 4 is 1, a write to IER, FCR or MCR updates every bit.
- R5: A write that takes bit 4 of the enhanced register from 1 to 0 saves the guarded fields and zeroes them. The zeroed view is visible on the first read after that write, and unguarded bits are unchanged.
- R6: A write that takes bit 4 from 0 to 1 restores the saved guarded fields. The unguarded bits written meanwhile are kept. The shadow resets to zero.
- R7: ISR[3:0] shows irq_code_i as registered one cycle earlier. ISR[5:4] are sticky flags set by evt_i only while bit 4 is 1, and a read of ISR clears them; a set in the same cycle wins. ISR[7:6] both equal FCR[0].
- R8: LSR shows lsr_i as registered one cycle earlier.
- R9: MSR[7:4] shows modem_i live. MSR[3:0] are sticky change flags, one per pin, set in the cycle after a pin changes and cleared by a read of MSR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (drives read side effects) |
| rdata_o | output | 8 | Read data for addr_i |
| irq_code_i | input | 4 | Interrupt code from the interrupt logic |
| evt_i | input | 2 | Enhanced interrupt event pulses |
| lsr_i | input | 8 | Line-status bits from the line logic |
| modem_i | input | 4 | Live modem input pins |
| ier_o | output | 8 | Visible IER |
| fcr_o | output | 8 | Visible FCR |
| lcr_o | output | 8 | LCR |
| mcr_o | output | 8 | Visible MCR |
| efr_o | output | 8 | Enhanced configuration register |

## Verification
Some properties hold on every cycle, and the assertions check them there. Guarded fields stay zero in legacy mode. Legacy writes land only on unguarded bits, and enhanced writes land in full. Unguarded bits survive a save. ISR flags stay clear in legacy mode, and LSR follows its input with one cycle of delay. Restoring shadow contents needs a history of earlier writes, so only the bench scenarios show it. The same holds for the shadow being zero after reset, for clear-on-read racing with a set, and for the modem change flags.

// File: rtl/uart_shreg_pkg.sv
package uart_shreg_pkg;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam int CODE_W = 4;
    localparam int EVT_W = 2;
    localparam int PIN_W = 4;
    localparam int ENH_BIT = 4;

    localparam logic [AW-1:0] A_IER = 4'd0;
    localparam logic [AW-1:0] A_ISR = 4'd1;
    localparam logic [AW-1:0] A_FCR = 4'd2;
    localparam logic [AW-1:0] A_LCR = 4'd3;
    localparam logic [AW-1:0] A_MCR = 4'd4;
    localparam logic [AW-1:0] A_LSR = 4'd5;
    localparam logic [AW-1:0] A_MSR = 4'd6;
    localparam logic [AW-1:0] A_SPR = 4'd7;
    localparam logic [AW-1:0] A_EFR = 4'd8;

    localparam logic [DW-1:0] IER_GUARD = 8'hF0;
    localparam logic [DW-1:0] FCR_GUARD = 8'h30;
    localparam logic [DW-1:0] MCR_GUARD = 8'hE0;

    localparam logic [DW-1:0] LSR_RST = 8'h60;
    localparam logic [DW-1:0] SPR_RST = 8'hFF;
    localparam logic [CODE_W-1:0] CODE_RST = 4'b0001;

    typedef struct packed {
        logic [DW-1:0] lcr;
        logic [DW-1:0] spr;
        logic [DW-1:0] efr;
        logic [DW-1:0] lsr;
    } misc_regs_t;
endpackage

// File: rtl/shadow_field_reg.sv
module shadow_field_reg #(
    parameter int W = 8,
    parameter logic [W-1:0] MASK = '0,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         enh_i,
    input  logic         save_i,
    input  logic         restore_i,
    output logic [W-1:0] value_o
);
    typedef struct packed {
        logic [W-1:0] vis;
        logic [W-1:0] shd;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (save_i) begin
            st_d.shd = st_q.vis & MASK;
            st_d.vis = st_q.vis & ~MASK;
        end else if (restore_i) begin
            st_d.vis = (st_q.vis & ~MASK) | (st_q.shd & MASK);
        end
        if (wr_i) begin
            if (enh_i) st_d.vis = wdata_i;
            else       st_d.vis = (st_d.vis & MASK) | (wdata_i & ~MASK);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.vis <= RST;
            st_q.shd <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value_o = st_q.vis;
endmodule

// File: rtl/isr_status_unit.sv
module isr_status_unit #(
    parameter int CODE_W = 4,
    parameter int EVT_W = 2,
    parameter logic [CODE_W-1:0] CODE_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_i,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic              enh_i,
    input  logic              save_i,
    input  logic              restore_i,
    input  logic              clr_i,
    output logic [CODE_W-1:0] code_o,
    output logic [EVT_W-1:0]  flags_o
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [EVT_W-1:0]  flags;
        logic [EVT_W-1:0]  shd;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.code = code_i;
        if (save_i) begin
            st_d.shd   = st_q.flags;
            st_d.flags = '0;
        end else if (restore_i) begin
            st_d.flags = st_q.shd;
        end else begin
            st_d.flags = (clr_i ? '0 : st_q.flags) | (enh_i ? evt_i : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.code  <= CODE_RST;
            st_q.flags <= '0;
            st_q.shd   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o  = st_q.code;
    assign flags_o = st_q.flags;
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins_i,
    input  logic         clr_i,
    output logic [N-1:0] delta_o
);
    typedef struct packed {
        logic [N-1:0] last;
        logic [N-1:0] delta;
        logic         armed;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.last  = pins_i;
        st_d.armed = 1'b1;
        st_d.delta = (clr_i ? '0 : st_q.delta)
                   | (st_q.armed ? (pins_i ^ st_q.last) : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign delta_o = st_q.delta;
endmodule

// File: rtl/uart_shreg_bank.sv
module uart_shreg_bank
    import uart_shreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output logic [DW-1:0]     rdata_o,
    input  logic [CODE_W-1:0] irq_code_i,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic [DW-1:0]     lsr_i,
    input  logic [PIN_W-1:0]  modem_i,
    output logic [DW-1:0]     ier_o,
    output logic [DW-1:0]     fcr_o,
    output logic [DW-1:0]     lcr_o,
    output logic [DW-1:0]     mcr_o,
    output logic [DW-1:0]     efr_o
);
    misc_regs_t misc_d, misc_q;

    logic enh, save, restore;
    logic wr_ier, wr_fcr, wr_mcr, wr_efr;
    logic rd_isr, rd_msr;
    logic [CODE_W-1:0] isr_code;
    logic [EVT_W-1:0]  isr_flags;
    logic [PIN_W-1:0]  msr_delta;
    logic [DW-1:0]     isr_view;
    logic [DW-1:0]     msr_view;
    logic [DW-1:0]     lsr_q;
    logic [DW-1:0]     spr_q;

    assign enh     = misc_q.efr[ENH_BIT];
    assign wr_ier  = wr_i && (addr_i == A_IER);
    assign wr_fcr  = wr_i && (addr_i == A_FCR);
    assign wr_mcr  = wr_i && (addr_i == A_MCR);
    assign wr_efr  = wr_i && (addr_i == A_EFR);
    assign rd_isr  = rd_i && (addr_i == A_ISR);
    assign rd_msr  = rd_i && (addr_i == A_MSR);
    assign save    = wr_efr &&  enh && !wdata_i[ENH_BIT];
    assign restore = wr_efr && !enh &&  wdata_i[ENH_BIT];

    always_comb begin
        misc_d = misc_q;
        misc_d.lsr = lsr_i;
        if (wr_i) begin
            unique case (addr_i)
                A_LCR:   misc_d.lcr = wdata_i;
                A_SPR:   misc_d.spr = wdata_i;
                A_EFR:   misc_d.efr = wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            misc_q.lcr <= '0;
            misc_q.spr <= SPR_RST;
            misc_q.efr <= '0;
            misc_q.lsr <= LSR_RST;
        end else begin
            misc_q <= misc_d;
        end
    end

    shadow_field_reg #(.W(DW), .MASK(IER_GUARD), .RST('0)) u_ier (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_ier), .wdata_i(wdata_i),
        .enh_i(enh), .save_i(save), .restore_i(restore), .value_o(ier_o)
    );

    shadow_field_reg #(.W(DW), .MASK(FCR_GUARD), .RST('0)) u_fcr (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_fcr), .wdata_i(wdata_i),
        .enh_i(enh), .save_i(save), .restore_i(restore), .value_o(fcr_o)
    );

    shadow_field_reg #(.W(DW), .MASK(MCR_GUARD), .RST('0)) u_mcr (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_mcr), .wdata_i(wdata_i),
        .enh_i(enh), .save_i(save), .restore_i(restore), .value_o(mcr_o)
    );

    isr_status_unit #(.CODE_W(CODE_W), .EVT_W(EVT_W), .CODE_RST(CODE_RST)) u_isr (
        .clk(clk), .rst_n(rst_n), .code_i(irq_code_i), .evt_i(evt_i),
        .enh_i(enh), .save_i(save), .restore_i(restore), .clr_i(rd_isr),
        .code_o(isr_code), .flags_o(isr_flags)
    );

    modem_status_unit #(.N(PIN_W)) u_msr (
        .clk(clk), .rst_n(rst_n), .pins_i(modem_i), .clr_i(rd_msr),
        .delta_o(msr_delta)
    );

    assign isr_view = {fcr_o[0], fcr_o[0], isr_flags, isr_code};
    assign msr_view = {modem_i, msr_delta};
    assign lsr_q    = misc_q.lsr;
    assign spr_q    = misc_q.spr;
    assign lcr_o    = misc_q.lcr;
    assign efr_o    = misc_q.efr;

    always_comb begin
        unique case (addr_i)
            A_IER:   rdata_o = ier_o;
            A_ISR:   rdata_o = isr_view;
            A_FCR:   rdata_o = fcr_o;
            A_LCR:   rdata_o = misc_q.lcr;
            A_MCR:   rdata_o = mcr_o;
            A_LSR:   rdata_o = misc_q.lsr;
            A_MSR:   rdata_o = msr_view;
            A_SPR:   rdata_o = misc_q.spr;
            A_EFR:   rdata_o = misc_q.efr;
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/uart_shreg_bank_chk.sv
module uart_shreg_bank_chk
    import uart_shreg_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr_i,
    input logic [DW-1:0] wdata_i,
    input logic          wr_i,
    input logic [DW-1:0] ier_o,
    input logic [DW-1:0] fcr_o,
    input logic [DW-1:0] mcr_o,
    input logic [DW-1:0] efr_o,
    input logic [DW-1:0] isr_view,
    input logic [DW-1:0] lsr_i,
    input logic [DW-1:0] lsr_q,
    input logic [DW-1:0] spr_q
);
    // R1
    reset_values_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ier_o == 8'h00 && efr_o == 8'h00 && spr_q == SPR_RST && lsr_q == LSR_RST));

    // R3
    legacy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !efr_o[ENH_BIT] |-> (ier_o[7:4] == 4'h0 && fcr_o[5:4] == 2'b00 && mcr_o[7:5] == 3'b000));

    // R3
    legacy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_IER && !efr_o[ENH_BIT]) |=> (ier_o == {4'h0, $past(wdata_i[3:0])}));

    // R4
    enh_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_MCR && efr_o[ENH_BIT]) |=> (mcr_o == $past(wdata_i)));

    // R5
    save_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_EFR && efr_o[ENH_BIT] && !wdata_i[ENH_BIT])
        |=> (ier_o[3:0] == $past(ier_o[3:0]) && ier_o[7:4] == 4'h0));

    // R7
    isr_flags_legacy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !efr_o[ENH_BIT] |-> (isr_view[5:4] == 2'b00));

    // R8
    lsr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lsr_q == $past(lsr_i)));
endmodule

bind uart_shreg_bank uart_shreg_bank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i), .wr_i(wr_i),
    .ier_o(ier_o), .fcr_o(fcr_o), .mcr_o(mcr_o), .efr_o(efr_o),
    .isr_view(isr_view), .lsr_i(lsr_i), .lsr_q(lsr_q), .spr_q(spr_q)
);

// File: tb/uart_shreg_bank_tb.sv
`timescale 1ns/1ps
module uart_shreg_bank_tb;
    import uart_shreg_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [AW-1:0]     addr_i = '0;
    logic [DW-1:0]     wdata_i = '0;
    logic              wr_i = 1'b0;
    logic              rd_i = 1'b0;
    logic [DW-1:0]     rdata_o;
    logic [CODE_W-1:0] irq_code_i = 4'b0001;
    logic [EVT_W-1:0]  evt_i = '0;
    logic [DW-1:0]     lsr_i = 8'h60;
    logic [PIN_W-1:0]  modem_i = '0;
    logic [DW-1:0]     ier_o, fcr_o, lcr_o, mcr_o, efr_o;

    int checks = 0;
    int fails = 0;
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    always #2 clk = ~clk;

    uart_shreg_bank u_dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
        .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o), .irq_code_i(irq_code_i),
        .evt_i(evt_i), .lsr_i(lsr_i), .modem_i(modem_i), .ier_o(ier_o),
        .fcr_o(fcr_o), .lcr_o(lcr_o), .mcr_o(mcr_o), .efr_o(efr_o)
    );

    // Monitor: pops one expected item per read strobe
    always @(negedge clk) begin
        if (rst_n && rd_i) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL monitor: read with empty scoreboard, actual %02h expected none", rdata_o);
            end else begin
                logic [DW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (rdata_o !== e) begin
                    fails++;
                    $display("FAIL %s: actual %02h expected %02h", t, rdata_o, e);
                end
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(posedge clk); #1;
        addr_i = a; wdata_i = d; wr_i = 1'b1;
        @(posedge clk); #1;
        wr_i = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
        @(posedge clk); #1;
        addr_i = a; rd_i = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(posedge clk); #1;
        rd_i = 1'b0;
    endtask

    task automatic pulse_evt(input logic [EVT_W-1:0] v);
        @(posedge clk); #1;
        evt_i = v;
        @(posedge clk); #1;
        evt_i = '0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #200000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        rd(A_IER, 8'h00, "R1 IER");
        rd(A_ISR, 8'h01, "R1 ISR");
        rd(A_FCR, 8'h00, "R1 FCR");
        rd(A_LCR, 8'h00, "R1 LCR");
        rd(A_MCR, 8'h00, "R1 MCR");
        rd(A_LSR, 8'h60, "R1 LSR");
        rd(A_MSR, 8'h00, "R1 MSR");
        rd(A_SPR, 8'hFF, "R1 scratch");
        rd(A_EFR, 8'h00, "R1 EFR");

        // R3 legacy writes only touch unguarded bits
        wr(A_IER, 8'hFF); rd(A_IER, 8'h0F, "R3 IER legacy");
        wr(A_FCR, 8'h3F); rd(A_FCR, 8'h0F, "R3 FCR legacy");
        wr(A_MCR, 8'hFF); rd(A_MCR, 8'h1F, "R3 MCR legacy");
        // R2 full-width registers
        wr(A_LCR, 8'hA5); rd(A_LCR, 8'hA5, "R2 LCR");
        wr(A_SPR, 8'h5A); rd(A_SPR, 8'h5A, "R2 scratch");
        // R7 ISR[7:6] mirror FCR[0]
        rd(A_ISR, 8'hC1, "R7 ISR fifo mirror");

        // R6 first enable restores all-zero shadow
        wr(A_EFR, 8'h10);
        rd(A_EFR, 8'h10, "R2 EFR");
        rd(A_IER, 8'h0F, "R6 IER zero shadow");
        rd(A_MCR, 8'h1F, "R6 MCR zero shadow");

        // R4 enhanced writes update everything
        wr(A_IER, 8'hFF); rd(A_IER, 8'hFF, "R4 IER");
        wr(A_FCR, 8'h3F); rd(A_FCR, 8'h3F, "R4 FCR");
        wr(A_MCR, 8'hFF); rd(A_MCR, 8'hFF, "R4 MCR");

        // R7 sticky flags, clear on read
        pulse_evt(2'b01);
        rd(A_ISR, 8'hD1, "R7 ISR flag set");
        rd(A_ISR, 8'hC1, "R7 ISR clear on read");
        pulse_evt(2'b10);

        // R5 save and zero
        wr(A_EFR, 8'h00);
        rd(A_IER, 8'h0F, "R5 IER zeroed");
        rd(A_FCR, 8'h0F, "R5 FCR zeroed");
        rd(A_MCR, 8'h1F, "R5 MCR zeroed");
        rd(A_ISR, 8'hC1, "R5 ISR flags zeroed");

        // R3 legacy write to guarded bits is ignored, low bits update
        wr(A_IER, 8'h3C); rd(A_IER, 8'h0C, "R3 IER partial");
        // R7 events ignored in legacy mode
        pulse_evt(2'b01);
        rd(A_ISR, 8'hC1, "R7 ISR event ignored");

        // R6 restore saved fields
        wr(A_EFR, 8'h10);
        rd(A_IER, 8'hFC, "R6 IER restored");
        rd(A_FCR, 8'h3F, "R6 FCR restored");
        rd(A_MCR, 8'hFF, "R6 MCR restored");
        rd(A_ISR, 8'hE1, "R6 ISR flag restored");

        // R8 line status follows input
        @(posedge clk); #1 lsr_i = 8'h21;
        rd(A_LSR, 8'h21, "R8 LSR");

        // R9 modem change flags
        @(posedge clk); #1 modem_i = 4'b1010;
        rd(A_MSR, 8'hAA, "R9 MSR delta set");
        rd(A_MSR, 8'hA0, "R9 MSR delta cleared");

        // R7 code follows input
        @(posedge clk); #1 irq_code_i = 4'b0100;
        rd(A_ISR, 8'hC4, "R7 ISR code");

        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule